// File: doc/BRIEF.md
# Pan-Tilt Centroid Servo Tracker

This block keeps a camera pointed at a tracked object. Once per video frame it receives the object's centroid in a 310×240 image, together with a count of detected objects. For each of the two axes it forms the error between the image centre and the centroid, and it runs a fixed-point proportional-derivative law with a small bounded integral term. The result is a servo pulse width, limited to the safe mechanical range. Two PWM generators turn these widths into the pan and tilt drive pulses.

All gain scaling uses shifts, and the block contains no multiplier. The host selects the proportional and derivative shift amounts for each axis at run time. The loop acts only when a target exists, the system is in a tracking mode and the user has enabled the servos. At any other time the commands freeze and the dynamic state is cleared. Each PWM generator picks up a new width only at the boundary of its period, so no pulse is ever cut short or stretched by an update.

Top module: `pt_tracker`

## Requirements
- R1: After reset, both pulse-width commands equal the mid-range value (PW_MIN+PW_MAX)/2.
- R2: The error for each axis is its setpoint minus the measured centroid, with setpoints x=155 and y=120. With zero state and the centroid at the setpoint, the command is the mid-range value.
- R3: The proportional contribution is the error shifted left by the axis's proportional shift input (0 to 15).
- R4: The derivative is the current error minus the error stored at the previous update. It is arithmetically shifted right by the axis's derivative shift input, and the current error is stored on every update.
- R5: The integral adds the error on each update and is clamped to ±ILIM. The clamped value, arithmetically shifted right by KI_SH, is added to the command. Command = mid-range + P + I + D.
- R6: Each command is clamped into [PW_MIN, PW_MAX].
- R7: An update happens only in a cycle in which frame_stb is high, comp_cnt is nonzero, track_mode is high and servo_en is high. In every other cycle both commands hold.
- R8: In any cycle in which comp_cnt is zero, track_mode is low or servo_en is low, the integral and the stored error return to zero.
- R9: Each PWM output is high for exactly the latched command cycles at the start of each PERIOD-cycle frame. The command is latched only at the last cycle of a period, so a change during a pulse affects only the next pulse.
- R10: A command changes in the cycle after the clock edge that samples the update strobe, and a single-cycle strobe causes a single update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_x | input | COORD_W | Centroid column |
| cen_y | input | COORD_W | Centroid row |
| comp_cnt | input | CNT_W | Number of detected objects |
| frame_stb | input | 1 | One-cycle strobe marking a new centroid |
| track_mode | input | 1 | System is in a tracking mode |
| servo_en | input | 1 | User servo enable |
| pan_kp_sh | input | GAIN_W | Pan proportional left shift |
| pan_kd_sh | input | GAIN_W | Pan derivative right shift |
| tilt_kp_sh | input | GAIN_W | Tilt proportional left shift |
| tilt_kd_sh | input | GAIN_W | Tilt derivative right shift |
| pan_cmd | output | PW_W | Clamped pan pulse width |
| tilt_cmd | output | PW_W | Clamped tilt pulse width |
| pan_pwm | output | 1 | Pan servo pulse |
| tilt_pwm | output | 1 | Tilt servo pulse |

## Verification
The embedded properties check four things on every cycle. The commands stay inside the mechanical range, and the integral stays within its bound. Commands are frozen whenever no qualified strobe is present, and the integral and stored error are cleared when tracking is disabled. A latched pulse width may change only at the period boundary. The exact arithmetic of the control law is shown only by the bench scenarios: the shift directions, derivative memory, integral saturation and the mid-range result after a disable. The same holds for the measured pulse lengths, including a command change made in the middle of a pulse.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int ACC_W = 32;
  typedef logic signed [ACC_W-1:0] pt_acc_t;

  function automatic pt_acc_t pt_clamp(input pt_acc_t v, input pt_acc_t lo, input pt_acc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/pt_axis_law.sv
module pt_axis_law
  import pt_pkg::*;
#(
  parameter int COORD_W  = 9,
  parameter int GAIN_W   = 4,
  parameter int SETPOINT = 155,
  parameter int ILIM     = 4096,
  parameter int KI_SH    = 4,
  parameter int PW_W     = 21,
  parameter int PW_MIN   = 50000,
  parameter int PW_MAX   = 150000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               stb,
  input  logic [COORD_W-1:0] meas,
  input  logic [GAIN_W-1:0]  kp_sh,
  input  logic [GAIN_W-1:0]  kd_sh,
  output logic [PW_W-1:0]    cmd
);
  localparam pt_acc_t SET_S  = pt_acc_t'(SETPOINT);
  localparam pt_acc_t LIM_HI = pt_acc_t'(ILIM);
  localparam pt_acc_t LIM_LO = -pt_acc_t'(ILIM);
  localparam pt_acc_t MIN_S  = pt_acc_t'(PW_MIN);
  localparam pt_acc_t MAX_S  = pt_acc_t'(PW_MAX);
  localparam pt_acc_t MID_S  = pt_acc_t'((PW_MIN + PW_MAX) / 2);

  pt_acc_t integ_q, integ_n, prev_q, prev_n;
  logic [PW_W-1:0] cmd_q, cmd_n;
  pt_acc_t err, integ_clip, deriv, raw, cmd_clip;

  always_comb begin
    err        = SET_S - pt_acc_t'({1'b0, meas});
    integ_clip = pt_clamp(integ_q + err, LIM_LO, LIM_HI);
    deriv      = err - prev_q;
    raw        = MID_S + (err <<< kp_sh) + (integ_clip >>> KI_SH) + (deriv >>> kd_sh);
    cmd_clip   = pt_clamp(raw, MIN_S, MAX_S);
  end

  always_comb begin
    integ_n = integ_q;
    prev_n  = prev_q;
    cmd_n   = cmd_q;
    if (!active) begin
      integ_n = '0;
      prev_n  = '0;
    end else if (stb) begin
      integ_n = integ_clip;
      prev_n  = err;
      cmd_n   = cmd_clip[PW_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      prev_q  <= '0;
      cmd_q   <= PW_W'((PW_MIN + PW_MAX) / 2);
    end else begin
      integ_q <= integ_n;
      prev_q  <= prev_n;
      cmd_q   <= cmd_n;
    end
  end

  assign cmd = cmd_q;

  a_r6_cmd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q >= PW_W'(PW_MIN)) && (cmd_q <= PW_W'(PW_MAX)));
  a_r5_integ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q >= LIM_LO) && (integ_q <= LIM_HI));
  a_r7_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && stb) |=> $stable(cmd_q));
  a_r8_idle_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (integ_q == '0) && (prev_q == '0));
endmodule

// File: rtl/pt_servo_pwm.sv
module pt_servo_pwm #(
  parameter int PERIOD = 2000000,
  parameter int PW_W   = 21,
  parameter int RST_W  = 100000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW_W-1:0] cmd,
  output logic            pwm
);
  localparam int CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PW_W-1:0]  width_q, width_n;
  logic             last;

  always_comb begin
    last    = (cnt_q == CNT_W'(PERIOD - 1));
    cnt_n   = last ? '0 : cnt_q + 1'b1;
    width_n = last ? cmd : width_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      width_q <= PW_W'(RST_W);
    end else begin
      cnt_q   <= cnt_n;
      width_q <= width_n;
    end
  end

  assign pwm = (PW_W'(cnt_q) < width_q);

  a_r9_width_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_W'(PERIOD - 1)) |=> $stable(width_q));
  a_r9_pulse_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && (width_q != '0)) |-> pwm);
endmodule

// File: rtl/pt_tracker.sv
module pt_tracker #(
  parameter int COORD_W = 9,
  parameter int CNT_W   = 8,
  parameter int GAIN_W  = 4,
  parameter int SET_X   = 155,
  parameter int SET_Y   = 120,
  parameter int ILIM    = 4096,
  parameter int KI_SH   = 4,
  parameter int PW_MIN  = 50000,
  parameter int PW_MAX  = 150000,
  parameter int PERIOD  = 2000000,
  localparam int PW_W   = $clog2(PERIOD + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] cen_x,
  input  logic [COORD_W-1:0] cen_y,
  input  logic [CNT_W-1:0]   comp_cnt,
  input  logic               frame_stb,
  input  logic               track_mode,
  input  logic               servo_en,
  input  logic [GAIN_W-1:0]  pan_kp_sh,
  input  logic [GAIN_W-1:0]  pan_kd_sh,
  input  logic [GAIN_W-1:0]  tilt_kp_sh,
  input  logic [GAIN_W-1:0]  tilt_kd_sh,
  output logic [PW_W-1:0]    pan_cmd,
  output logic [PW_W-1:0]    tilt_cmd,
  output logic               pan_pwm,
  output logic               tilt_pwm
);
  localparam int N_AX = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic active;
  assign active = (comp_cnt != '0) && track_mode && servo_en;

  logic [COORD_W-1:0] meas_a [N_AX];
  logic [GAIN_W-1:0]  kp_a   [N_AX];
  logic [GAIN_W-1:0]  kd_a   [N_AX];
  logic [PW_W-1:0]    cmd_a  [N_AX];
  logic               pwm_a  [N_AX];

  assign meas_a[0] = cen_x;
  assign meas_a[1] = cen_y;
  assign kp_a[0]   = pan_kp_sh;
  assign kp_a[1]   = tilt_kp_sh;
  assign kd_a[0]   = pan_kd_sh;
  assign kd_a[1]   = tilt_kd_sh;

  for (genvar g = 0; g < N_AX; g++) begin : g_axis
    pt_axis_law #(
      .COORD_W (COORD_W),
      .GAIN_W  (GAIN_W),
      .SETPOINT((g == 0) ? SET_X : SET_Y),
      .ILIM    (ILIM),
      .KI_SH   (KI_SH),
      .PW_W    (PW_W),
      .PW_MIN  (PW_MIN),
      .PW_MAX  (PW_MAX)
    ) law_i (
      .clk   (clk),
      .rst_n (rst_n_s),
      .active(active),
      .stb   (frame_stb),
      .meas  (meas_a[g]),
      .kp_sh (kp_a[g]),
      .kd_sh (kd_a[g]),
      .cmd   (cmd_a[g])
    );

    pt_servo_pwm #(
      .PERIOD(PERIOD),
      .PW_W  (PW_W),
      .RST_W ((PW_MIN + PW_MAX) / 2)
    ) pwm_i (
      .clk  (clk),
      .rst_n(rst_n_s),
      .cmd  (cmd_a[g]),
      .pwm  (pwm_a[g])
    );
  end

  assign pan_cmd  = cmd_a[0];
  assign tilt_cmd = cmd_a[1];
  assign pan_pwm  = pwm_a[0];
  assign tilt_pwm = pwm_a[1];
endmodule

// File: tb/pt_tracker_tb_top.sv
`timescale 1ns/1ps
module pt_tracker_tb_top;
  localparam int PMIN = 1000, PMAX = 3000, PER = 4000, ILM = 64, KIS = 2;
  localparam int MID  = (PMIN + PMAX) / 2;
  localparam int PWW  = $clog2(PER + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] cen_x = '0, cen_y = '0;
  logic [7:0] comp_cnt = '0;
  logic frame_stb = 1'b0, track_mode = 1'b0, servo_en = 1'b0;
  logic [3:0] pkp = '0, pkd = '0, tkp = '0, tkd = '0;
  logic [PWW-1:0] pan_cmd, tilt_cmd;
  logic pan_pwm, tilt_pwm;

  always #2 clk = ~clk;

  pt_tracker #(.ILIM(ILM), .KI_SH(KIS), .PW_MIN(PMIN), .PW_MAX(PMAX), .PERIOD(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .cen_x(cen_x), .cen_y(cen_y), .comp_cnt(comp_cnt),
    .frame_stb(frame_stb), .track_mode(track_mode), .servo_en(servo_en),
    .pan_kp_sh(pkp), .pan_kd_sh(pkd), .tilt_kp_sh(tkp), .tilt_kd_sh(tkd),
    .pan_cmd(pan_cmd), .tilt_cmd(tilt_cmd), .pan_pwm(pan_pwm), .tilt_pwm(tilt_pwm));

  int total = 0, bad = 0;
  bit finished = 0;

  // entry: {cx[8:0], cy[8:0], cnt[7:0], mode, user, kp[3:0], kd[3:0]}
  localparam logic [35:0] VEC [12] = '{
    {9'd155, 9'd120, 8'd1, 1'b1, 1'b1, 4'd0, 4'd0},
    {9'd100, 9'd100, 8'd1, 1'b1, 1'b1, 4'd1, 4'd1},
    {9'd120, 9'd140, 8'd3, 1'b1, 1'b1, 4'd1, 4'd1},
    {9'd300, 9'd10,  8'd1, 1'b1, 1'b1, 4'd2, 4'd0},
    {9'd0,   9'd239, 8'd1, 1'b1, 1'b1, 4'd4, 4'd0},
    {9'd40,  9'd40,  8'd0, 1'b1, 1'b1, 4'd1, 4'd1},
    {9'd155, 9'd120, 8'd1, 1'b1, 1'b1, 4'd0, 4'd0},
    {9'd20,  9'd20,  8'd1, 1'b0, 1'b1, 4'd1, 4'd0},
    {9'd20,  9'd20,  8'd1, 1'b1, 1'b0, 4'd1, 4'd0},
    {9'd50,  9'd60,  8'd1, 1'b1, 1'b1, 4'd3, 4'd0},
    {9'd50,  9'd60,  8'd1, 1'b1, 1'b1, 4'd3, 4'd0},
    {9'd200, 9'd200, 8'd2, 1'b1, 1'b1, 4'd0, 4'd2}
  };

  longint mi [2], mp [2], mc [2];

  task automatic check(input longint act, input longint exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int ax, input longint meas, input bit act, input int kp, input int kd);
    longint e, s, d, raw;
    if (!act) begin mi[ax] = 0; mp[ax] = 0; return; end
    e = ((ax == 0) ? 155 : 120) - meas;
    s = mi[ax] + e;
    if (s > ILM) s = ILM;
    if (s < -ILM) s = -ILM;
    d = e - mp[ax];
    raw = MID + (e <<< kp) + (s >>> KIS) + (d >>> kd);
    if (raw < PMIN) raw = PMIN;
    if (raw > PMAX) raw = PMAX;
    mi[ax] = s; mp[ax] = e; mc[ax] = raw;
  endtask

  task automatic drive(input int cx, input int cy, input int cn, input bit md, input bit us,
                       input int kp, input int kd);
    bit act;
    cen_x = 9'(cx); cen_y = 9'(cy); comp_cnt = 8'(cn);
    track_mode = md; servo_en = us;
    pkp = 4'(kp); tkp = 4'(kp); pkd = 4'(kd); tkd = 4'(kd);
    frame_stb = 1'b1;
    act = (cn != 0) && md && us;
    model(0, cx, act, kp, kd);
    model(1, cy, act, kp, kd);
  endtask

  task automatic apply(input int cx, input int cy, input int cn, input bit md, input bit us,
                       input int kp, input int kd);
    @(negedge clk);
    drive(cx, cy, cn, md, us, kp, kd);
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic measure(input bit tilt, output int n);
    n = 0;
    @(negedge clk);
    while ((tilt ? tilt_pwm : pan_pwm) == 1'b1) @(negedge clk);
    while ((tilt ? tilt_pwm : pan_pwm) == 1'b0) @(negedge clk);
    while ((tilt ? tilt_pwm : pan_pwm) == 1'b1) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    longint old_pan, new_pan;
    mi = '{0, 0}; mp = '{0, 0}; mc = '{MID, MID};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pan_cmd, MID, "R1 pan reset");
    check(tilt_cmd, MID, "R1 tilt reset");

    apply(155, 120, 1, 1, 1, 3, 0);
    check(pan_cmd, MID, "R2 pan centred");
    check(tilt_cmd, MID, "R2 tilt centred");

    for (int i = 0; i < 12; i++) begin
      apply(int'(VEC[i][35:27]), int'(VEC[i][26:18]), int'(VEC[i][17:10]), VEC[i][9], VEC[i][8],
            int'(VEC[i][7:4]), int'(VEC[i][3:0]));
      check(pan_cmd, mc[0], $sformatf("R3 R4 R5 pan vec%0d", i));
      check(tilt_cmd, mc[1], $sformatf("R3 R4 R5 tilt vec%0d", i));
    end

    // saturation from cleared state
    apply(0, 0, 0, 1, 1, 0, 0);
    apply(0, 239, 1, 1, 1, 4, 0);
    check(pan_cmd, PMAX, "R6 pan upper clamp");
    check(tilt_cmd, PMIN, "R6 tilt lower clamp");

    // active but no strobe: hold
    @(negedge clk);
    cen_x = 9'd155; cen_y = 9'd120; pkp = '0; tkp = '0;
    repeat (6) @(negedge clk);
    check(pan_cmd, PMAX, "R7 pan hold without strobe");
    check(tilt_cmd, PMIN, "R7 tilt hold without strobe");
    apply(155, 120, 0, 1, 1, 0, 0);
    check(pan_cmd, PMAX, "R7 pan hold zero count");
    apply(155, 120, 1, 1, 0, 0, 0);
    check(tilt_cmd, PMIN, "R7 tilt hold user off");

    apply(155, 120, 1, 1, 1, 0, 0);
    check(pan_cmd, MID, "R8 pan state cleared");
    check(tilt_cmd, MID, "R8 tilt state cleared");

    // update timing
    @(negedge clk);
    drive(145, 120, 1, 1, 1, 0, 0);
    check(pan_cmd, MID, "R10 pan before edge");
    @(negedge clk);
    frame_stb = 1'b0;
    check(pan_cmd, mc[0], "R10 pan after edge");
    check(pan_cmd, MID + 22, "R10 pan value");
    @(negedge clk);
    check(pan_cmd, MID + 22, "R10 pan single update");

    // PWM
    measure(1'b0, n);
    check(n, mc[0], "R9 pan pulse width");
    measure(1'b1, n);
    check(n, mc[1], "R9 tilt pulse width");
    old_pan = mc[0];
    @(negedge clk);
    while (pan_pwm == 1'b1) @(negedge clk);
    while (pan_pwm == 1'b0) @(negedge clk);
    n = 0;
    while (pan_pwm == 1'b1) begin
      n++;
      if (n == 10) drive(155, 120, 1, 1, 1, 0, 0);
      @(negedge clk);
      frame_stb = 1'b0;
    end
    new_pan = mc[0];
    check(n, old_pan, "R9 pulse unchanged by mid-pulse update");
    measure(1'b0, n);
    check(n, new_pan, "R9 next pulse uses new command");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule